// File: doc/BRIEF.md
# NIC Control Register File

This block is the 32-bit control and status register space of one network controller function. A host-side request port delivers single word accesses. Each access names one of two address spaces, a word address, a byte count and write data. The block decodes the access into one of four targets: indexed control arrays for interrupt vectors and queues, the two admin-queue ring descriptors (transmit and receive), a small set of special control words, or fixed identity words.

Every access gets exactly one response, one clock later. The response carries registered read data, a size error flag, and a flag marking an access that hit no mapped register. Writes can have side effects. A software reset request leaves as a one-cycle pulse, and any write to a ring descriptor field leaves as a one-cycle update strobe for the queue engine attached to that ring. The ring base, length, head and tail values are driven out continuously to that engine.

Word map (word addresses, memory space): 0x000 general control, 0x001 NVM lock word, 0x002 queue allocation, 0x003 virtual-function allocation, 0x004 port number, 0x005 receive control. Transmit ring fields sit at 0x040..0x044 and receive ring fields at 0x048..0x04C, each in the order base-low, base-high, length, head, tail. The vector control array starts at 0x400, the vector rate array at 0x500 and the queue control array at 0x600.

Top module: `nic_csr_file`

## Requirements
- R1: An access whose `req_bytes` is not 4 is rejected. Its response has `rsp_err`=1, `rsp_rdata`=0 and `rsp_unmapped`=0, and it changes no register and raises no pulse.
- R2: Every request cycle with `req_valid`=1 produces `rsp_valid`=1 exactly one cycle later, and no other cycle does. A read returns its data in that same cycle. A write returns `rsp_rdata`=0.
- R3: The vector control array (0x400+i, i<NUM_VEC), the vector rate array (0x500+i, i<NUM_VEC) and the queue control array (0x600+i, i<NUM_Q) each read back the full 32-bit word last written to that entry. Indices at or past the depth are unmapped.
- R4: A write to 0x000 with bit 0 set gives `soft_reset_pulse`=1 for one cycle, in the response cycle. A write with bit 0 clear gives no pulse. Reads of 0x000 always return 0.
- R5: Bit 0 of 0x005 is the network-boot flag. Hardware reset sets it. Writing 1 to it clears it, and writing 0 leaves it unchanged. Bits 31:1 read 0.
- R6: Each ring base is 64 bits, with the low half at field 0 and the high half at field 1. Writing one half leaves the other half unchanged. `aq_base[q]`, `aq_len[q]`, `aq_head[q]` and `aq_tail[q]` show the stored values (q=0 transmit, q=1 receive).
- R7: Any write to a field of ring q raises `aq_upd[q]` for one cycle, in the response cycle. The other ring's strobe stays low.
- R8: The fixed words read as follows. The NVM lock word reads 0xFFFFFFFF. The queue allocation word reads first queue 0 in bits 10:0, NUM_Q−1 in bits 26:16 and the valid bit 31 set (0x800F0000 for 16 queues). The virtual-function allocation and port number words read 0. Writes to these words have no effect.
- R9: In the I/O space (`req_space`=1), word addresses 0..7 read 0, ignore writes and are not flagged unmapped. Higher I/O addresses are unmapped.
- R10: An unmapped legal access reads 0, changes nothing, and has `rsp_unmapped`=1 in its response cycle.
- R11: Hardware reset clears every array entry and every ring field to 0, and clears all response and pulse outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Access request present this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_space | input | 1 | 0 memory space, 1 I/O space |
| req_addr | input | 20 | Word address |
| req_bytes | input | 3 | Access size in bytes (only 4 is legal) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access size error |
| rsp_unmapped | output | 1 | Legal access hit no register |
| soft_reset_pulse | output | 1 | Software reset request pulse |
| aq_upd | output | 2 | Per-ring update strobe (0 transmit, 1 receive) |
| aq_base | output | 2x64 | Ring base addresses |
| aq_len | output | 2x32 | Ring length words |
| aq_head | output | 2x32 | Ring head words |
| aq_tail | output | 2x32 | Ring tail words |

## Verification
All results of a request arrive exactly one clock after it: read data, error, unmapped flag, reset pulse and ring strobes. Stored state, and the continuously driven ring outputs, change at the request's own clock edge. The bench drives a request at a falling edge and samples every response output at the next falling edge, which lies just after the single register stage. It checks the ring outputs at that same point, against a model updated when the request was issued. A request issued right after a write therefore sees that write, and any strobe or pulse that came a cycle early or late is caught as a mismatch.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;

  localparam int ADDR_W    = 20;
  localparam int DATA_W    = 32;
  localparam int IO_WORDS  = 8;
  localparam int ACC_BYTES = 4;
  localparam int NUM_RING  = 2;
  localparam int NUM_ARR   = 3;
  localparam int IDX_W     = 8;

  // special and fixed words (word addresses, memory space)
  localparam logic [ADDR_W-1:0] W_CTRL    = 20'h00000;
  localparam logic [ADDR_W-1:0] W_NVMLOCK = 20'h00001;
  localparam logic [ADDR_W-1:0] W_QALLOC  = 20'h00002;
  localparam logic [ADDR_W-1:0] W_VFALLOC = 20'h00003;
  localparam logic [ADDR_W-1:0] W_PORT    = 20'h00004;
  localparam logic [ADDR_W-1:0] W_RXCTL   = 20'h00005;
  localparam logic [ADDR_W-1:0] W_RING    = 20'h00040;
  localparam logic [ADDR_W-1:0] W_ARR     = 20'h00400;

  // ring field codes, in address order inside a ring
  localparam logic [2:0] RF_BLO  = 3'd0;
  localparam logic [2:0] RF_BHI  = 3'd1;
  localparam logic [2:0] RF_LEN  = 3'd2;
  localparam logic [2:0] RF_HEAD = 3'd3;
  localparam logic [2:0] RF_TAIL = 3'd4;

  // array ids, one 256-word slot each
  localparam int AR_VCTL  = 0;
  localparam int AR_VRATE = 1;
  localparam int AR_QCTL  = 2;

  localparam int CTRL_SWRST_BIT = 0;
  localparam int RXCTL_BOOT_BIT = 0;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CTRL, SEL_NVMLOCK, SEL_QALLOC, SEL_VFALLOC,
    SEL_PORT, SEL_RXCTL, SEL_RING, SEL_ARR, SEL_IO
  } sel_e;

  typedef struct packed {
    sel_e             sel;
    logic             ring_id;
    logic [2:0]       field;
    logic [1:0]       arr_id;
    logic [IDX_W-1:0] idx;
  } dec_t;

endpackage

// File: rtl/nic_csr_decode.sv
module nic_csr_decode
  import nic_csr_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int NUM_Q   = 16
) (
  input  logic              space,
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);

  logic [1:0]       slot;
  logic [IDX_W-1:0] slot_idx;
  logic             slot_ok;

  assign slot     = addr[9:8];
  assign slot_idx = addr[7:0];

  always_comb begin
    unique case (slot)
      2'(AR_VCTL), 2'(AR_VRATE): slot_ok = int'(slot_idx) < NUM_VEC;
      2'(AR_QCTL):               slot_ok = int'(slot_idx) < NUM_Q;
      default:                   slot_ok = 1'b0;
    endcase
  end

  always_comb begin
    dec = '0;
    dec.sel = SEL_NONE;
    if (space) begin
      if (int'(addr) < IO_WORDS) dec.sel = SEL_IO;
    end else if (addr == W_CTRL) begin
      dec.sel = SEL_CTRL;
    end else if (addr == W_NVMLOCK) begin
      dec.sel = SEL_NVMLOCK;
    end else if (addr == W_QALLOC) begin
      dec.sel = SEL_QALLOC;
    end else if (addr == W_VFALLOC) begin
      dec.sel = SEL_VFALLOC;
    end else if (addr == W_PORT) begin
      dec.sel = SEL_PORT;
    end else if (addr == W_RXCTL) begin
      dec.sel = SEL_RXCTL;
    end else if (addr[ADDR_W-1:4] == W_RING[ADDR_W-1:4]) begin
      if (addr[2:0] <= RF_TAIL) begin
        dec.sel     = SEL_RING;
        dec.ring_id = addr[3];
        dec.field   = addr[2:0];
      end
    end else if (addr[ADDR_W-1:10] == W_ARR[ADDR_W-1:10]) begin
      if (slot_ok) begin
        dec.sel    = SEL_ARR;
        dec.arr_id = slot;
        dec.idx    = slot_idx;
      end
    end
  end

endmodule

// File: rtl/nic_csr_regarray.sv
module nic_csr_regarray
  import nic_csr_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] ent [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic              hit;
    logic [DATA_W-1:0] val_d;
    logic [DATA_W-1:0] val_q;

    assign hit = wr_en && (idx == IDX_W'(i));

    always_comb begin
      val_d = val_q;
      if (hit) val_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else        val_q <= val_d;
    end

    assign ent[i] = val_q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (idx == IDX_W'(i)) rd_data = ent[i];
    end
  end

endmodule

// File: rtl/nic_csr_ring.sv
module nic_csr_ring
  import nic_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        field,
  input  logic [DATA_W-1:0] wr_data,
  output logic [63:0]       base,
  output logic [DATA_W-1:0] len,
  output logic [DATA_W-1:0] head,
  output logic [DATA_W-1:0] tail,
  output logic [DATA_W-1:0] rd_data,
  output logic              upd
);

  logic [DATA_W-1:0] blo_q, bhi_q, len_q, head_q, tail_q;
  logic [DATA_W-1:0] blo_d, bhi_d, len_d, head_d, tail_d;
  logic              upd_q;

  always_comb begin
    blo_d  = blo_q;
    bhi_d  = bhi_q;
    len_d  = len_q;
    head_d = head_q;
    tail_d = tail_q;
    if (wr_en) begin
      unique case (field)
        RF_BLO:  blo_d  = wr_data;
        RF_BHI:  bhi_d  = wr_data;
        RF_LEN:  len_d  = wr_data;
        RF_HEAD: head_d = wr_data;
        RF_TAIL: tail_d = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blo_q  <= '0;
      bhi_q  <= '0;
      len_q  <= '0;
      head_q <= '0;
      tail_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      blo_q  <= blo_d;
      bhi_q  <= bhi_d;
      len_q  <= len_d;
      head_q <= head_d;
      tail_q <= tail_d;
      upd_q  <= wr_en;
    end
  end

  always_comb begin
    unique case (field)
      RF_BLO:  rd_data = blo_q;
      RF_BHI:  rd_data = bhi_q;
      RF_LEN:  rd_data = len_q;
      RF_HEAD: rd_data = head_q;
      RF_TAIL: rd_data = tail_q;
      default: rd_data = '0;
    endcase
  end

  assign base = {bhi_q, blo_q};
  assign len  = len_q;
  assign head = head_q;
  assign tail = tail_q;
  assign upd  = upd_q;

endmodule

// File: rtl/nic_csr_file.sv
module nic_csr_file
  import nic_csr_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int NUM_Q   = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             req_valid,
  input  logic                             req_write,
  input  logic                             req_space,
  input  logic [ADDR_W-1:0]                req_addr,
  input  logic [2:0]                       req_bytes,
  input  logic [DATA_W-1:0]                req_wdata,
  output logic                             rsp_valid,
  output logic [DATA_W-1:0]                rsp_rdata,
  output logic                             rsp_err,
  output logic                             rsp_unmapped,
  output logic                             soft_reset_pulse,
  output logic [NUM_RING-1:0]              aq_upd,
  output logic [NUM_RING-1:0][63:0]        aq_base,
  output logic [NUM_RING-1:0][DATA_W-1:0]  aq_len,
  output logic [NUM_RING-1:0][DATA_W-1:0]  aq_head,
  output logic [NUM_RING-1:0][DATA_W-1:0]  aq_tail
);

  localparam logic [DATA_W-1:0] QALLOC_WORD =
    {1'b1, 4'b0, 11'(NUM_Q - 1), 5'b0, 11'd0};

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta_q} <= 2'b00;
    else        {rst_sync_n, rst_meta_q} <= {rst_meta_q, 1'b1};
  end

  dec_t dec;
  nic_csr_decode #(.NUM_VEC(NUM_VEC), .NUM_Q(NUM_Q)) u_dec (
    .space (req_space),
    .addr  (req_addr),
    .dec   (dec)
  );

  logic acc_ok, wr_ok;
  assign acc_ok = req_valid && (req_bytes == 3'(ACC_BYTES));
  assign wr_ok  = acc_ok && req_write;

  // indexed arrays
  logic [DATA_W-1:0] arr_rd [NUM_ARR];
  for (genvar a = 0; a < NUM_ARR; a++) begin : g_arr
    localparam int DEPTH = (a == AR_QCTL) ? NUM_Q : NUM_VEC;
    nic_csr_regarray #(.DEPTH(DEPTH)) u_arr (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr_en   (wr_ok && dec.sel == SEL_ARR && dec.arr_id == 2'(a)),
      .idx     (dec.idx),
      .wr_data (req_wdata),
      .rd_data (arr_rd[a])
    );
  end

  // admin rings
  logic [DATA_W-1:0] ring_rd [NUM_RING];
  for (genvar q = 0; q < NUM_RING; q++) begin : g_ring
    nic_csr_ring u_ring (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr_en   (wr_ok && dec.sel == SEL_RING && dec.ring_id == 1'(q)),
      .field   (dec.field),
      .wr_data (req_wdata),
      .base    (aq_base[q]),
      .len     (aq_len[q]),
      .head    (aq_head[q]),
      .tail    (aq_tail[q]),
      .rd_data (ring_rd[q]),
      .upd     (aq_upd[q])
    );
  end

  // network-boot flag: set on reset, write-one-to-clear
  logic boot_q, boot_d;
  always_comb begin
    boot_d = boot_q;
    if (wr_ok && dec.sel == SEL_RXCTL && req_wdata[RXCTL_BOOT_BIT]) boot_d = 1'b0;
  end

  // read mux
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    unique case (dec.sel)
      SEL_NVMLOCK: rd_mux = '1;
      SEL_QALLOC:  rd_mux = QALLOC_WORD;
      SEL_RXCTL:   rd_mux = DATA_W'(boot_q) << RXCTL_BOOT_BIT;
      SEL_RING:    rd_mux = ring_rd[dec.ring_id];
      SEL_ARR:     rd_mux = (int'(dec.arr_id) < NUM_ARR) ? arr_rd[dec.arr_id] : '0;
      default:     rd_mux = '0;
    endcase
  end

  // response next state
  logic              vld_d, err_d, unm_d, srst_d;
  logic [DATA_W-1:0] rdata_d;
  logic              vld_q, err_q, unm_q, srst_q;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    vld_d   = req_valid;
    err_d   = req_valid && !acc_ok;
    unm_d   = acc_ok && dec.sel == SEL_NONE;
    srst_d  = wr_ok && dec.sel == SEL_CTRL && req_wdata[CTRL_SWRST_BIT];
    rdata_d = (acc_ok && !req_write) ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      boot_q  <= 1'b1;
      vld_q   <= 1'b0;
      err_q   <= 1'b0;
      unm_q   <= 1'b0;
      srst_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      boot_q  <= boot_d;
      vld_q   <= vld_d;
      err_q   <= err_d;
      unm_q   <= unm_d;
      srst_q  <= srst_d;
      rdata_q <= rdata_d;
    end
  end

  assign rsp_valid        = vld_q;
  assign rsp_rdata        = rdata_q;
  assign rsp_err          = err_q;
  assign rsp_unmapped     = unm_q;
  assign soft_reset_pulse = srst_q;

endmodule

// File: rtl/nic_csr_file_chk.sv
module nic_csr_file_chk
  import nic_csr_pkg::*;
(
  input logic                             clk,
  input logic                             rst_n,
  input logic                             req_valid,
  input logic                             req_write,
  input logic                             req_space,
  input logic [ADDR_W-1:0]                req_addr,
  input logic [2:0]                       req_bytes,
  input logic [DATA_W-1:0]                req_wdata,
  input logic                             rsp_valid,
  input logic [DATA_W-1:0]                rsp_rdata,
  input logic                             rsp_err,
  input logic                             rsp_unmapped,
  input logic                             soft_reset_pulse,
  input logic [NUM_RING-1:0]              aq_upd,
  input logic [NUM_RING-1:0][63:0]        aq_base,
  input logic [NUM_RING-1:0][DATA_W-1:0]  aq_len,
  input logic [NUM_RING-1:0][DATA_W-1:0]  aq_head,
  input logic [NUM_RING-1:0][DATA_W-1:0]  aq_tail
);

  logic legal, mem_rd, mem_wr;
  assign legal  = req_valid && req_bytes == 3'd4;
  assign mem_rd = legal && !req_write && !req_space;
  assign mem_wr = legal && req_write && !req_space;

  a_r1_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_bytes != 3'd4 |=> rsp_err && rsp_rdata == '0 && !rsp_unmapped);

  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r2_rsp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !soft_reset_pulse && aq_upd == '0);

  a_r4_ctrl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && req_addr == 20'h0 |=> rsp_rdata == '0);

  a_r4_swrst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr && req_addr == 20'h0 && req_wdata[0] |=> soft_reset_pulse);

  a_r6_hi_kept: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr && req_addr == 20'h40 |=> aq_base[0][63:32] == $past(aq_base[0][63:32]));

  a_r6_lo_kept: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr && req_addr == 20'h41 |=> aq_base[0][31:0] == $past(aq_base[0][31:0]));

  a_r7_tx_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr && req_addr >= 20'h40 && req_addr <= 20'h44 |=> aq_upd[0] && !aq_upd[1]);

  a_r8_nvm_lock: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && req_addr == 20'h1 |=> rsp_rdata == 32'hFFFF_FFFF);

  a_r9_io_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    legal && req_space && req_addr < 20'd8 |=> rsp_rdata == '0 && !rsp_unmapped);

  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> !rsp_unmapped);

endmodule

bind nic_csr_file nic_csr_file_chk u_chk (.*);

// File: tb/nic_csr_file_test.sv
`timescale 1ns/1ps
module nic_csr_file_test;
  localparam int NV = 8;
  localparam int NQ = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_write, req_space;
  logic [19:0] req_addr;
  logic [2:0]  req_bytes;
  logic [31:0] req_wdata;
  logic        rsp_valid, rsp_err, rsp_unmapped, soft_reset_pulse;
  logic [31:0] rsp_rdata;
  logic [1:0]  aq_upd;
  logic [1:0][63:0] aq_base;
  logic [1:0][31:0] aq_len, aq_head, aq_tail;

  always #2.5 clk = ~clk;

  nic_csr_file #(.NUM_VEC(NV), .NUM_Q(NQ)) uut (
    .clk, .rst_n, .req_valid, .req_write, .req_space, .req_addr, .req_bytes,
    .req_wdata, .rsp_valid, .rsp_rdata, .rsp_err, .rsp_unmapped,
    .soft_reset_pulse, .aq_upd, .aq_base, .aq_len, .aq_head, .aq_tail
  );

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;

  // reference model
  logic [31:0] m_vctl [NV];
  logic [31:0] m_vrate[NV];
  logic [31:0] m_qctl [NQ];
  logic [31:0] m_ring [2][5];
  logic        m_boot;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < NV; i++) begin m_vctl[i] = '0; m_vrate[i] = '0; end
    for (int i = 0; i < NQ; i++) m_qctl[i] = '0;
    for (int q = 0; q < 2; q++) for (int f = 0; f < 5; f++) m_ring[q][f] = '0;
    m_boot = 1'b1;
  endtask

  function automatic bit is_ring(logic [19:0] a);
    return (a >= 20'h40 && a <= 20'h44) || (a >= 20'h48 && a <= 20'h4C);
  endfunction

  function automatic bit mapped(bit sp, logic [19:0] a);
    if (sp) return a < 20'd8;
    return a <= 20'h5 || is_ring(a) ||
           (a >= 20'h400 && a < 20'h400 + NV) ||
           (a >= 20'h500 && a < 20'h500 + NV) ||
           (a >= 20'h600 && a < 20'h600 + NQ);
  endfunction

  function automatic logic [31:0] model_read(bit sp, logic [19:0] a);
    if (sp) return '0;
    if (a == 20'h1) return 32'hFFFF_FFFF;
    if (a == 20'h2) return (32'h1 << 31) | (32'(NQ - 1) << 16);
    if (a == 20'h5) return {31'b0, m_boot};
    if (is_ring(a)) return m_ring[a[3]][a[2:0]];
    if (a >= 20'h400 && a < 20'h400 + NV) return m_vctl[a - 20'h400];
    if (a >= 20'h500 && a < 20'h500 + NV) return m_vrate[a - 20'h500];
    if (a >= 20'h600 && a < 20'h600 + NQ) return m_qctl[a - 20'h600];
    return '0;
  endfunction

  function automatic string tag_of(bit sp, logic [19:0] a, logic [2:0] by);
    if (by != 3'd4) return "R1";
    if (sp) return "R9";
    if (!mapped(sp, a)) return "R10";
    if (a == 20'h0) return "R4";
    if (a == 20'h5) return "R5";
    if (a <= 20'h4) return "R8";
    if (is_ring(a)) return "R6";
    return "R3";
  endfunction

  // one access: drive at a falling edge, check at the next one
  task automatic access(bit w, bit sp, logic [19:0] a, logic [2:0] by,
                        logic [31:0] d, string tag);
    logic [31:0] e_rd;
    logic        e_err, e_unm, e_srst;
    logic [1:0]  e_upd;
    bit          ok;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_space = sp;
    req_addr = a; req_bytes = by; req_wdata = d;
    ok     = (by == 3'd4);
    e_err  = !ok;
    e_unm  = ok && !mapped(sp, a);
    e_rd   = (ok && !w) ? model_read(sp, a) : '0;
    e_srst = ok && w && !sp && a == 20'h0 && d[0];
    e_upd  = '0;
    if (ok && w && !sp && is_ring(a)) e_upd[a[3]] = 1'b1;
    if (ok && w && !sp) begin
      if (a == 20'h5 && d[0]) m_boot = 1'b0;
      if (is_ring(a)) m_ring[a[3]][a[2:0]] = d;
      if (a >= 20'h400 && a < 20'h400 + NV) m_vctl[a - 20'h400] = d;
      if (a >= 20'h500 && a < 20'h500 + NV) m_vrate[a - 20'h500] = d;
      if (a >= 20'h600 && a < 20'h600 + NQ) m_qctl[a - 20'h600] = d;
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R2 valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " rdata"}, 64'(rsp_rdata), 64'(e_rd));
    chk({tag, " R1 err"}, 64'(rsp_err), 64'(e_err));
    chk({tag, " R10 unmapped"}, 64'(rsp_unmapped), 64'(e_unm));
    chk({tag, " R4 pulse"}, 64'(soft_reset_pulse), 64'(e_srst));
    chk({tag, " R7 strobe"}, 64'(aq_upd), 64'(e_upd));
    chk({tag, " R6 tx base"}, aq_base[0], {m_ring[0][1], m_ring[0][0]});
    chk({tag, " R6 rx base"}, aq_base[1], {m_ring[1][1], m_ring[1][0]});
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    chk("R11 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    chk("R11 tx base in reset", aq_base[0], 64'd0);
    chk("R11 tail in reset", 64'(aq_tail[1]), 64'd0);
    chk("R11 pulses in reset", 64'({soft_reset_pulse, aq_upd}), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog expired actual=hang expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [19:0] a;
    logic [2:0]  by;
    bit          sp, w;
    req_valid = 0; req_write = 0; req_space = 0;
    req_addr = '0; req_bytes = 3'd4; req_wdata = '0;
    rst_n = 1'b0;
    void'($urandom(32'd20240517));
    hw_reset();

    // R8 fixed words and R5 reset state
    access(0, 0, 20'h1, 4, 0, "R8 nvm lock");
    access(0, 0, 20'h2, 4, 0, "R8 queue alloc");
    access(0, 0, 20'h3, 4, 0, "R8 vf alloc");
    access(0, 0, 20'h4, 4, 0, "R8 port");
    access(1, 0, 20'h1, 4, 32'h0, "R8 write ignored");
    access(0, 0, 20'h1, 4, 0, "R8 nvm after write");
    access(0, 0, 20'h5, 4, 0, "R5 boot set after reset");
    access(1, 0, 20'h5, 4, 32'hFFFF_FFFE, "R5 write zero bit");
    access(0, 0, 20'h5, 4, 0, "R5 boot kept");
    access(1, 0, 20'h5, 4, 32'h1, "R5 write one clears");
    access(0, 0, 20'h5, 4, 0, "R5 boot cleared");

    // R4 software reset
    access(1, 0, 20'h0, 4, 32'h1, "R4 reset write");
    access(1, 0, 20'h0, 4, 32'hFFFF_FFFE, "R4 no reset bit");
    access(0, 0, 20'h0, 4, 0, "R4 read zero");

    // R6 / R7 split base, both rings
    access(1, 0, 20'h40, 4, 32'hDEAD_BEEF, "R6 tx lo");
    access(1, 0, 20'h41, 4, 32'h0000_0012, "R6 tx hi");
    access(1, 0, 20'h40, 4, 32'h1111_2222, "R6 tx lo again");
    access(1, 0, 20'h49, 4, 32'hCAFE_0001, "R7 rx hi");
    access(1, 0, 20'h44, 4, 32'd7, "R7 tx tail");
    access(0, 0, 20'h41, 4, 0, "R6 tx hi read");
    access(0, 0, 20'h44, 4, 0, "R6 tx tail read");
    access(1, 0, 20'h45, 4, 32'h5, "R10 ring hole");

    // R3 array bounds
    access(1, 0, 20'h400, 4, 32'hA5A5_0001, "R3 vctl first");
    access(1, 0, 20'h400 + NV - 1, 4, 32'hA5A5_0002, "R3 vctl last");
    access(1, 0, 20'h400 + NV, 4, 32'h1234, "R3 vctl past end");
    access(0, 0, 20'h400 + NV, 4, 0, "R3 past end reads 0");
    access(1, 0, 20'h600 + NQ - 1, 4, 32'h0BAD_F00D, "R3 qctl last");
    access(0, 0, 20'h400, 4, 0, "R3 vctl first read");
    access(0, 0, 20'h600 + NQ - 1, 4, 0, "R3 qctl last read");
    access(0, 0, 20'h700, 4, 0, "R10 fourth slot");

    // R1 sizes, R9 io, R10 unmapped
    access(1, 0, 20'h401, 2, 32'hFFFF_FFFF, "R1 short write");
    access(0, 0, 20'h401, 2, 0, "R1 short read");
    access(0, 0, 20'h401, 4, 0, "R1 entry untouched");
    access(1, 0, 20'h0, 1, 32'h1, "R1 no pulse");
    access(1, 1, 20'h3, 4, 32'hFFFF_FFFF, "R9 io write");
    access(0, 1, 20'h3, 4, 0, "R9 io read");
    access(0, 1, 20'h8, 4, 0, "R9 io beyond window");
    access(1, 0, 20'hF_FFFF, 4, 32'h1, "R10 top write");
    access(0, 0, 20'h6, 4, 0, "R10 after fixed words");

    // constrained random
    for (int n = 0; n < 600; n++) begin
      w  = $urandom_range(1, 0) == 1;
      sp = 1'b0;
      by = ($urandom_range(9, 0) == 0) ? 3'($urandom_range(3, 1) * 2 - 1) : 3'd4;
      case ($urandom_range(9, 0))
        0: a = 20'h400 + 20'($urandom_range(NV - 1, 0));
        1: a = 20'h500 + 20'($urandom_range(NV - 1, 0));
        2, 3: a = 20'h600 + 20'($urandom_range(NQ - 1, 0));
        4: a = 20'h40 + 20'($urandom_range(1, 0) * 8) + 20'($urandom_range(4, 0));
        5: a = 20'($urandom_range(5, 0));
        6: begin sp = 1'b1; a = 20'($urandom_range(9, 0)); end
        7: a = 20'h400 + 20'($urandom_range(255, NV));
        8: a = 20'($urandom_range(20'hFFFFF, 20'h800));
        default: a = 20'h48 + 20'($urandom_range(7, 0));
      endcase
      access(w, sp, a, by, $urandom, tag_of(sp, a, by));
    end

    // R11 hardware reset clears storage
    hw_reset();
    access(0, 0, 20'h600, 4, 0, "R11 qctl cleared");
    access(0, 0, 20'h48, 4, 0, "R11 rx base lo cleared");
    access(0, 0, 20'h5, 4, 0, "R11 boot set again");

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule